// File: doc/BRIEF.md
# Hardware Loop Unit

This unit keeps the loop state that lets a small in-order core repeat a body of code with no branch instruction and no cycle lost at the loop's back edge. There are four loop slots. Each slot holds a start address, an end address and a remaining-iteration count. Loop setup instructions reach the unit already decoded. The unit takes the slot number and the operation from the instruction word. The PCs, the two immediates and the source register value arrive on their own ports. One shared adder forms the target address, and the unit then loads any mix of the three fields of the chosen slot at the next clock edge.

On every fetch the unit compares the fetch PC with the end address of each slot. Only a slot with a non-zero count takes part in this compare. When the lowest-numbered such slot holds a count above one, the unit requests a redirect to that slot's start address in the same cycle and decrements the count. When that slot's count is exactly one, the unit only takes the count to zero, so fetch falls through and leaves the loop.

Top module: `zloop_unit`

## Requirements
- R1: An active-low reset clears every start, end and count field to zero. Afterwards no fetch PC produces a jump request.
- R2: Operation 000 (instruction bits [14:12]) writes only the start field. The value written is setup PC plus the I-type immediate.
- R3: Operation 001 writes only the end field. The value written is setup PC plus the I-type immediate.
- R4: Operation 010 loads the count from the source register value. Operation 011 loads the count from the low bits of the I-type immediate.
- R5: Operation 100 writes all three fields of the slot. Start becomes the next-instruction PC, end becomes setup PC plus the I-type immediate, and count becomes the source register value.
- R6: Operation 101 writes all three fields of the slot. Start becomes the next-instruction PC, end becomes setup PC plus the Z-type immediate shifted left by one, and count becomes the source register value.
- R7: Operations 110 and 111 with setup valid raise `illegal_op` in the same cycle and write no field. `illegal_op` is low whenever setup valid is low.
- R8: The slot is chosen by instruction bits [8:7]. Only that slot is written, and only while `setup_valid` is high.
- R9: When a valid fetch PC equals a slot's end address and that slot's count is above one, `jump_req` is high in the same cycle and `jump_addr` equals the slot's start. The count drops by one at the next edge.
- R10: When the count at the matching end address is one, `jump_req` stays low and the count becomes zero.
- R11: A slot whose count is zero never requests a jump and keeps its count.
- R12: When several slots with non-zero count match the fetch PC, only the lowest index acts, both for the jump and for the decrement.
- R13: When a count load targets the same slot as a fetch decrement in the same cycle, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_valid | input | 1 | A decoded loop setup instruction is present |
| setup_insn | input | 32 | Setup instruction word; slot in [8:7], operation in [14:12] |
| setup_pc | input | ADDR_W | PC of the setup instruction |
| setup_next_pc | input | ADDR_W | PC of the instruction after it |
| setup_imm_i | input | ADDR_W | Sign-extended I-type immediate |
| setup_imm_z | input | ADDR_W | Zero-extended Z-type immediate |
| setup_rs1 | input | CNT_W | Source register value |
| fetch_valid | input | 1 | Fetch PC is valid this cycle |
| fetch_pc | input | ADDR_W | Current fetch PC |
| jump_req | output | 1 | Redirect fetch to the loop start |
| jump_addr | output | ADDR_W | Redirect address |
| illegal_op | output | 1 | Setup used a reserved operation |

## Verification
The checker assumes that the fetch PC and the setup fields are stable and known in every cycle in which their valid is high. It also assumes that the slot and operation bits of a setup instruction are meaningful only while `setup_valid` is high. The bench changes inputs only on the falling edge, so each value is settled well before the rising edge that uses it. It holds every valid low outside the cycles it means to drive. A same-cycle setup and fetch on the same slot happens only in the one directed case written for it, so that case is the only one where the write-priority rule decides the count.

// File: rtl/zloop_pkg.sv
package zloop_pkg;

  typedef enum logic [2:0] {
    OP_SET_START = 3'b000,
    OP_SET_END   = 3'b001,
    OP_CNT_REG   = 3'b010,
    OP_CNT_IMM   = 3'b011,
    OP_SETUP_I   = 3'b100,
    OP_SETUP_Z   = 3'b101
  } zl_op_e;

  typedef struct packed {
    logic wr_start;
    logic wr_end;
    logic wr_cnt;
  } zl_wr_t;

  typedef struct packed {
    zl_wr_t wr;
    logic   tgt_zimm;
    logic   start_npc;
    logic   cnt_reg;
    logic   illegal;
  } zl_ctrl_t;

endpackage

// File: rtl/zloop_decode.sv
module zloop_decode
  import zloop_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] op,
  output zl_ctrl_t   ctrl
);

  always_comb begin
    ctrl = '0;
    if (valid) begin
      case (op)
        OP_SET_START: ctrl.wr.wr_start = 1'b1;
        OP_SET_END:   ctrl.wr.wr_end   = 1'b1;
        OP_CNT_REG: begin
          ctrl.wr.wr_cnt = 1'b1;
          ctrl.cnt_reg   = 1'b1;
        end
        OP_CNT_IMM:   ctrl.wr.wr_cnt   = 1'b1;
        OP_SETUP_I: begin
          ctrl.wr        = '{wr_start: 1'b1, wr_end: 1'b1, wr_cnt: 1'b1};
          ctrl.start_npc = 1'b1;
          ctrl.cnt_reg   = 1'b1;
        end
        OP_SETUP_Z: begin
          ctrl.wr        = '{wr_start: 1'b1, wr_end: 1'b1, wr_cnt: 1'b1};
          ctrl.tgt_zimm  = 1'b1;
          ctrl.start_npc = 1'b1;
          ctrl.cnt_reg   = 1'b1;
        end
        default:      ctrl.illegal     = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/zloop_target.sv
module zloop_target #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              sel_zimm,
  input  logic              sel_npc,
  input  logic              sel_reg,
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [ADDR_W-1:0] imm_i,
  input  logic [ADDR_W-1:0] imm_z,
  input  logic [CNT_W-1:0]  rs1,
  output logic [ADDR_W-1:0] start_val,
  output logic [ADDR_W-1:0] end_val,
  output logic [CNT_W-1:0]  cnt_val
);

  logic [ADDR_W-1:0] offset;
  logic [ADDR_W-1:0] target;
  logic              unused_zimm_msb;

  // single shared adder; the Z immediate is a half-word offset
  assign offset          = sel_zimm ? {imm_z[ADDR_W-2:0], 1'b0} : imm_i;
  assign target          = pc + offset;
  assign unused_zimm_msb = imm_z[ADDR_W-1];

  assign end_val   = target;
  assign start_val = sel_npc ? next_pc : target;
  assign cnt_val   = sel_reg ? rs1 : CNT_W'(imm_i);

endmodule

// File: rtl/zloop_match.sv
module zloop_match #(
  parameter int NUM_LOOPS = 4,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(NUM_LOOPS)
) (
  input  logic                              fetch_valid,
  input  logic [ADDR_W-1:0]                 fetch_pc,
  input  logic [NUM_LOOPS-1:0][ADDR_W-1:0]  end_q,
  input  logic [NUM_LOOPS-1:0][CNT_W-1:0]   cnt_q,
  output logic                              hit,
  output logic [IDX_W-1:0]                  hit_idx,
  output logic                              hit_live
);

  logic [NUM_LOOPS-1:0] match;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_cmp
    assign match[g] = fetch_valid && (end_q[g] == fetch_pc) && (cnt_q[g] != '0);
  end

  // lowest index wins
  always_comb begin
    hit_idx = '0;
    for (int i = NUM_LOOPS - 1; i >= 0; i--) begin
      if (match[i]) hit_idx = IDX_W'(i);
    end
  end

  assign hit      = |match;
  assign hit_live = hit && (cnt_q[hit_idx] > CNT_W'(1));

endmodule

// File: rtl/zloop_unit.sv
module zloop_unit
  import zloop_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              setup_valid,
  input  logic [31:0]       setup_insn,
  input  logic [ADDR_W-1:0] setup_pc,
  input  logic [ADDR_W-1:0] setup_next_pc,
  input  logic [ADDR_W-1:0] setup_imm_i,
  input  logic [ADDR_W-1:0] setup_imm_z,
  input  logic [CNT_W-1:0]  setup_rs1,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic              jump_req,
  output logic [ADDR_W-1:0] jump_addr,
  output logic              illegal_op
);

  localparam int IDX_W     = 2;
  localparam int NUM_LOOPS = 1 << IDX_W;
  localparam int IDX_LSB   = 7;
  localparam int OP_LSB    = 12;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // instruction fields
  logic [IDX_W-1:0] setup_idx;
  logic [2:0]       setup_op;
  logic             unused_insn_bits;

  assign setup_idx        = setup_insn[IDX_LSB +: IDX_W];
  assign setup_op         = setup_insn[OP_LSB +: 3];
  assign unused_insn_bits = ^{setup_insn[31:15], setup_insn[11:9], setup_insn[6:0]};

  zl_ctrl_t          ctrl;
  logic [ADDR_W-1:0] start_val;
  logic [ADDR_W-1:0] end_val;
  logic [CNT_W-1:0]  cnt_val;

  zloop_decode u_dec (
    .valid (setup_valid),
    .op    (setup_op),
    .ctrl  (ctrl)
  );

  zloop_target #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_tgt (
    .sel_zimm  (ctrl.tgt_zimm),
    .sel_npc   (ctrl.start_npc),
    .sel_reg   (ctrl.cnt_reg),
    .pc        (setup_pc),
    .next_pc   (setup_next_pc),
    .imm_i     (setup_imm_i),
    .imm_z     (setup_imm_z),
    .rs1       (setup_rs1),
    .start_val (start_val),
    .end_val   (end_val),
    .cnt_val   (cnt_val)
  );

  // loop state
  logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q;
  logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_q;
  logic [NUM_LOOPS-1:0][CNT_W-1:0]  cnt_q;
  logic [NUM_LOOPS-1:0][CNT_W-1:0]  cnt_d;
  logic [NUM_LOOPS-1:0]             en_start;
  logic [NUM_LOOPS-1:0]             en_end;
  logic [NUM_LOOPS-1:0]             en_cnt;

  logic             hit;
  logic [IDX_W-1:0] hit_idx;
  logic             hit_live;

  zloop_match #(.NUM_LOOPS(NUM_LOOPS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .end_q       (end_q),
    .cnt_q       (cnt_q),
    .hit         (hit),
    .hit_idx     (hit_idx),
    .hit_live    (hit_live)
  );

  // next state and clock enables
  always_comb begin
    for (int i = 0; i < NUM_LOOPS; i++) begin
      en_start[i] = (setup_idx == IDX_W'(i)) && ctrl.wr.wr_start;
      en_end[i]   = (setup_idx == IDX_W'(i)) && ctrl.wr.wr_end;
      en_cnt[i]   = ((setup_idx == IDX_W'(i)) && ctrl.wr.wr_cnt) ||
                    (hit && (hit_idx == IDX_W'(i)));
      // a count load takes priority over the fetch decrement
      if ((setup_idx == IDX_W'(i)) && ctrl.wr.wr_cnt) cnt_d[i] = cnt_val;
      else                                             cnt_d[i] = cnt_q[i] - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      start_q <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_LOOPS; i++) begin
        if (en_start[i]) start_q[i] <= start_val;
        if (en_end[i])   end_q[i]   <= end_val;
        if (en_cnt[i])   cnt_q[i]   <= cnt_d[i];
      end
    end
  end

  assign jump_req   = hit_live;
  assign jump_addr  = start_q[hit_idx];
  assign illegal_op = ctrl.illegal;

endmodule

// File: rtl/zloop_unit_chk.sv
module zloop_unit_chk #(
  parameter int NUM_LOOPS = 4,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 32,
  localparam int IDX_W    = $clog2(NUM_LOOPS)
) (
  input logic                             clk,
  input logic                             rst_ni,
  input logic                             setup_valid,
  input logic [2:0]                       setup_op,
  input logic [IDX_W-1:0]                 setup_idx,
  input logic                             wr_cnt,
  input logic                             fetch_valid,
  input logic [ADDR_W-1:0]                fetch_pc,
  input logic                             jump_req,
  input logic [ADDR_W-1:0]                jump_addr,
  input logic                             illegal_op,
  input logic                             hit,
  input logic [IDX_W-1:0]                 hit_idx,
  input logic [NUM_LOOPS-1:0][ADDR_W-1:0] start_q,
  input logic [NUM_LOOPS-1:0][ADDR_W-1:0] end_q,
  input logic [NUM_LOOPS-1:0][CNT_W-1:0]  cnt_q
);

  logic [CNT_W-1:0] hit_cnt;
  logic             lower_match;
  logic             pend;
  logic [IDX_W-1:0] pidx;
  logic [CNT_W-1:0] pcnt;

  assign hit_cnt = cnt_q[hit_idx];

  always_comb begin
    lower_match = 1'b0;
    for (int i = 0; i < NUM_LOOPS; i++) begin
      if ((i < int'(hit_idx)) && (end_q[i] == fetch_pc) && (cnt_q[i] != '0))
        lower_match = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend <= 1'b0;
      pidx <= '0;
      pcnt <= '0;
    end else begin
      pend <= hit && !(wr_cnt && (setup_idx == hit_idx));
      pidx <= hit_idx;
      pcnt <= hit_cnt;
    end
  end

  assert_illegal_flag_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (setup_valid && (setup_op[2:1] == 2'b11)) |-> illegal_op);

  assert_illegal_no_write_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    illegal_op |=> ($stable(start_q) && $stable(end_q)));

  assert_start_only_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    (setup_valid && (setup_op == 3'b000)) |=> $stable(end_q));

  assert_jump_at_end_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    jump_req |-> (fetch_valid && (end_q[hit_idx] == fetch_pc) && (jump_addr == start_q[hit_idx])));

  assert_jump_count_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    jump_req |-> (hit_cnt > CNT_W'(1)));

  assert_decrement_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    pend |-> (cnt_q[pidx] == CNT_W'(pcnt - CNT_W'(1))));

  assert_lowest_wins_R12: assert property (@(posedge clk) disable iff (!rst_ni)
    hit |-> !lower_match);

endmodule

bind zloop_unit zloop_unit_chk #(
  .NUM_LOOPS (NUM_LOOPS),
  .ADDR_W    (ADDR_W),
  .CNT_W     (CNT_W)
) u_chk (
  .clk         (clk),
  .rst_ni      (rst_sync_n),
  .setup_valid (setup_valid),
  .setup_op    (setup_op),
  .setup_idx   (setup_idx),
  .wr_cnt      (ctrl.wr.wr_cnt),
  .fetch_valid (fetch_valid),
  .fetch_pc    (fetch_pc),
  .jump_req    (jump_req),
  .jump_addr   (jump_addr),
  .illegal_op  (illegal_op),
  .hit         (hit),
  .hit_idx     (hit_idx),
  .start_q     (start_q),
  .end_q       (end_q),
  .cnt_q       (cnt_q)
);

// File: tb/zloop_unit_tb.sv
module zloop_unit_tb;

  localparam int AW = 32;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          setup_valid;
  logic [31:0]   setup_insn;
  logic [AW-1:0] setup_pc, setup_next_pc, setup_imm_i, setup_imm_z;
  logic [CW-1:0] setup_rs1;
  logic          fetch_valid;
  logic [AW-1:0] fetch_pc;
  logic          jump_req;
  logic [AW-1:0] jump_addr;
  logic          illegal_op;

  int n_checks = 0;
  int n_err    = 0;

  always #4 clk = ~clk;  // 125 MHz

  zloop_unit #(.ADDR_W(AW), .CNT_W(CW)) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .setup_valid   (setup_valid),
    .setup_insn    (setup_insn),
    .setup_pc      (setup_pc),
    .setup_next_pc (setup_next_pc),
    .setup_imm_i   (setup_imm_i),
    .setup_imm_z   (setup_imm_z),
    .setup_rs1     (setup_rs1),
    .fetch_valid   (fetch_valid),
    .fetch_pc      (fetch_pc),
    .jump_req      (jump_req),
    .jump_addr     (jump_addr),
    .illegal_op    (illegal_op)
  );

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  idx;
    logic [31:0] pc;
    logic [31:0] npc;
    logic [31:0] immi;
    logic [31:0] immz;
    logic [31:0] rs1;
    logic        ill;
    logic [31:0] ppc;
    logic [7:0]  njmp;
    logic [31:0] paddr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 32'h100, 32'h104, 32'h40,       32'h0,  32'd0, 1'b0, 32'h000, 8'd0, 32'h000},
    '{3'd1, 2'd0, 32'h100, 32'h104, 32'h80,       32'h0,  32'd0, 1'b0, 32'h180, 8'd0, 32'h000},
    '{3'd2, 2'd0, 32'h100, 32'h104, 32'h0,        32'h0,  32'd3, 1'b0, 32'h180, 8'd2, 32'h140},
    '{3'd3, 2'd0, 32'h100, 32'h104, 32'h2,        32'h0,  32'd0, 1'b0, 32'h180, 8'd1, 32'h140},
    '{3'd4, 2'd1, 32'h200, 32'h204, 32'h3C,       32'h0,  32'd4, 1'b0, 32'h23C, 8'd3, 32'h204},
    '{3'd5, 2'd2, 32'h300, 32'h304, 32'h0,        32'h20, 32'd2, 1'b0, 32'h340, 8'd1, 32'h304},
    '{3'd6, 2'd3, 32'h400, 32'h404, 32'h10,       32'h0,  32'd5, 1'b1, 32'h410, 8'd0, 32'h000},
    '{3'd7, 2'd3, 32'h400, 32'h404, 32'h10,       32'h0,  32'd5, 1'b1, 32'h410, 8'd0, 32'h000},
    '{3'd4, 2'd3, 32'h500, 32'h504, 32'hFFFFFFE0, 32'h0,  32'd2, 1'b0, 32'h4E0, 8'd1, 32'h504}
  };

  function automatic string tag_of(input logic [2:0] op);
    case (op)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R4";
      3'd4:    return "R5";
      3'd5:    return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    setup_valid   = 1'b0;
    setup_insn    = '0;
    setup_pc      = '0;
    setup_next_pc = '0;
    setup_imm_i   = '0;
    setup_imm_z   = '0;
    setup_rs1     = '0;
    fetch_valid   = 1'b0;
    fetch_pc      = '0;
  endtask

  task automatic drive_setup(input logic v, input logic [2:0] op, input logic [1:0] idx,
                             input logic [31:0] pc, npc, immi, immz, rs1);
    setup_valid   = v;
    setup_insn    = (32'(op) << 12) | (32'(idx) << 7);
    setup_pc      = pc;
    setup_next_pc = npc;
    setup_imm_i   = immi;
    setup_imm_z   = immz;
    setup_rs1     = rs1;
  endtask

  // one setup cycle; illegal flag sampled mid-cycle
  task automatic do_setup(input string req, input logic v, input logic [2:0] op,
                          input logic [1:0] idx, input logic [31:0] pc, npc, immi, immz, rs1,
                          input logic exp_ill);
    @(negedge clk);
    drive_setup(v, op, idx, pc, npc, immi, immz, rs1);
    #2;
    check(req, "illegal_op", 32'(illegal_op), 32'(exp_ill));
    @(negedge clk);
    idle();
  endtask

  // fetch at pc until no jump; then one more fetch must not jump either
  task automatic probe(input string req, input logic [31:0] pc,
                       input int exp_jumps, input logic [31:0] exp_addr);
    int  jumps = 0;
    bit  done  = 0;
    for (int k = 0; k < 20 && !done; k++) begin
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_pc    = pc;
      #2;
      if (jump_req) begin
        jumps++;
        if (jumps == 1) check(req, "jump_addr", jump_addr, exp_addr);
      end else begin
        done = 1;
      end
    end
    check(req, "jump count", 32'(jumps), 32'(exp_jumps));
    @(negedge clk);
    #2;
    check("R11", "no jump once drained", 32'(jump_req), 32'd0);
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    idle();
    do_reset();

    // R1: reset state
    @(negedge clk);
    #2;
    check("R1", "jump_req after reset", 32'(jump_req), 32'd0);
    check("R1", "illegal_op after reset", 32'(illegal_op), 32'd0);

    // vector table: setup followed by a probe of the slot's end address (R8 via slot field)
    for (int v = 0; v < NV; v++) begin
      do_setup(tag_of(VECS[v].op), 1'b1, VECS[v].op, VECS[v].idx, VECS[v].pc,
               VECS[v].npc, VECS[v].immi, VECS[v].immz, VECS[v].rs1, VECS[v].ill);
      probe(tag_of(VECS[v].op), VECS[v].ppc, int'(VECS[v].njmp), VECS[v].paddr);
    end

    // R10: count of one leaves the loop and clears the count
    do_setup("R10", 1'b1, 3'd4, 2'd1, 32'h700, 32'h6A0, 32'h80, 32'h0, 32'd1, 1'b0);
    probe("R10", 32'h780, 0, 32'h0);

    // R7 and R8: nothing happens without setup_valid
    do_setup("R7", 1'b0, 3'd6, 2'd3, 32'h800, 32'h804, 32'h0, 32'h0, 32'd4, 1'b0);
    do_setup("R8", 1'b0, 3'd4, 2'd3, 32'h800, 32'h804, 32'h40, 32'h0, 32'd4, 1'b0);
    probe("R8", 32'h840, 0, 32'h0);

    // R12: two slots share one end address
    do_setup("R12", 1'b1, 3'd4, 2'd0, 32'h5C0, 32'h500, 32'h40, 32'h0, 32'd3, 1'b0);
    do_setup("R12", 1'b1, 3'd4, 2'd1, 32'h5C0, 32'h580, 32'h40, 32'h0, 32'd5, 1'b0);
    for (int k = 0; k < 8; k++) begin
      logic        ej;
      logic [31:0] ea;
      ej = !(k == 2 || k == 7);
      ea = (k < 2) ? 32'h500 : 32'h580;
      @(negedge clk);
      fetch_valid = 1'b1;
      fetch_pc    = 32'h600;
      #2;
      check("R12", "jump_req", 32'(jump_req), 32'(ej));
      if (ej) check("R12", "jump_addr", jump_addr, ea);
    end
    @(negedge clk);
    idle();

    // R13: count load and decrement on the same slot in one cycle
    do_setup("R13", 1'b1, 3'd4, 2'd2, 32'h6C0, 32'h6F0, 32'h40, 32'h0, 32'd5, 1'b0);
    @(negedge clk);
    drive_setup(1'b1, 3'd2, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'd2);
    fetch_valid = 1'b1;
    fetch_pc    = 32'h700;
    #2;
    check("R13", "jump_req with load", 32'(jump_req), 32'd1);
    check("R13", "jump_addr with load", jump_addr, 32'h6F0);
    @(negedge clk);
    idle();
    probe("R13", 32'h700, 1, 32'h6F0);

    // R1: reset mid-run clears a live loop
    do_setup("R1", 1'b1, 3'd2, 2'd2, 32'h0, 32'h0, 32'h0, 32'h0, 32'd6, 1'b0);
    @(negedge clk);
    rst_n       = 1'b0;
    fetch_valid = 1'b1;
    fetch_pc    = 32'h700;
    #2;
    check("R1", "jump_req in reset", 32'(jump_req), 32'd0);
    @(negedge clk);
    idle();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    probe("R1", 32'h700, 0, 32'h0);
    probe("R1", 32'h0, 0, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

endmodule